// File: doc/BRIEF.md
# SSD Patch-Matching Feature Tracker

This block follows image features from one frame to the next. Each feature position (x, y) found in frame i enters on a valid/ready stream. The block asks its pixel source for two windows around that position. One is the (2r+1)×(2r+1) reference patch from frame i. The other is the (4r+1)×(4r+1) area of frame i+1 that covers every shifted patch. The block then scores every displacement (b, s) with b and s in −r..r at the same time. The score is the sum of squared differences between the reference patch and the patch shifted by (b, s). A comparison tree selects the cheapest displacement, and the matched position x+b, y+s leaves on an output stream together with its cost.

The search radius r is not set by hand. It follows from the image size: r is the smallest integer k with (256·k)² ≥ W² + H². This is the same as k ≥ ½·√((W/128)² + (H/128)²). Tracking runs frame by frame. The pixel source first pairs frame i with frame i+1, and the next pass pairs frame i+1 with frame i+2.

A feature whose search area would cross the image border is not searched. It is forwarded with its own coordinates and a no-match flag. Matches always leave in the order their features arrived.

Top module: `ssd_tracker`

## Requirements
- R1: The radius is derived from IMG_W and IMG_H as the smallest k ≥ 1 with 65536·k² ≥ IMG_W² + IMG_H². For 384×256 this gives 2, so a true shift of 2 pixels in x is still found.
- R2: For an in-bounds feature, out_x = x + b and out_y = y + s, where (b, s) is the displacement with the lowest SSD cost. out_cost equals that cost, and out_nomatch = 0.
- R3: Among displacements of equal cost, the one with the smallest |b|+|s| is chosen. A featureless scene therefore reports displacement (0, 0).
- R4: Ties that remain after R3 go to the displacement that comes first in raster order: s ascending, then b ascending.
- R5: A feature with x < 2r, x > W−1−2r, y < 2r or y > H−1−2r leaves with out_nomatch = 1, out_x = x, out_y = y and out_cost = 0. No fetch is made for it.
- R6: While out_valid = 1 and out_ready = 0, the output fields hold steady and in_ready = 0. No feature is lost or reordered under backpressure.
- R7: The pixel source is asked once per in-bounds feature, in arrival order. The request is fetch_en = 1 with fetch_x/fetch_y equal to the feature. cur_win element (v·P+u) holds frame-i pixel (x+u−r, y+v−r), with P = 2r+1. nxt_win element (j·Q+i) holds frame-i+1 pixel (x+i−2r, y+j−2r), with Q = 4r+1. Both windows are 8-bit per pixel, element 0 in the low bits, and are valid from the clock edge at which fetch_en is sampled until the next request.
- R8: After reset, out_valid = 0, fetch_en = 0 and in_ready = 1.
- R9: With out_ready held at 1, one feature is accepted every cycle. Its match appears three cycles after the cycle in which it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Feature present |
| in_ready | output | 1 | Feature taken this cycle when in_valid is also 1 |
| in_x | input | XW | Feature column in frame i |
| in_y | input | YW | Feature row in frame i |
| fetch_en | output | 1 | Window request for the pixel source |
| fetch_x | output | XW | Requested centre column |
| fetch_y | output | YW | Requested centre row |
| cur_win | input | P·P·PIX_W | Frame-i patch around the requested centre |
| nxt_win | input | Q·Q·PIX_W | Frame-i+1 search area around the requested centre |
| out_valid | output | 1 | Match present |
| out_ready | input | 1 | Consumer takes the match |
| out_x | output | XW | Matched column in frame i+1 |
| out_y | output | YW | Matched row in frame i+1 |
| out_cost | output | CW | Minimum SSD cost |
| out_nomatch | output | 1 | Feature too close to the border; no search done |

## Verification
Two events can fall into the same cycle: a match stuck at the output under backpressure, and a window request that is due for the next feature already in flight. The request must then wait, so the window registers still hold the pixels of the feature that was fetched earlier. The bench provokes this by dropping out_ready on a fixed cycle pattern while features stream in back to back, across scenes with known shifts, stripe patterns that produce ties, and border positions. It judges the outcome in three ways. Every match is compared with a brute-force SSD search computed in the bench. Every request address is compared with the queue of accepted in-bounds features. The held output fields are compared from cycle to cycle.

// File: rtl/ssd_tracker.sv
module ssd_tracker #(
  parameter int IMG_W = 384,
  parameter int IMG_H = 256,
  parameter int PIX_W = 8,
  localparam int D2 = IMG_W * IMG_W + IMG_H * IMG_H,
  localparam int R = (D2 <=  1 * 65536) ? 1 : (D2 <=  4 * 65536) ? 2 :
                     (D2 <=  9 * 65536) ? 3 : (D2 <= 16 * 65536) ? 4 :
                     (D2 <= 25 * 65536) ? 5 : (D2 <= 36 * 65536) ? 6 :
                     (D2 <= 49 * 65536) ? 7 : (D2 <= 64 * 65536) ? 8 :
                     (D2 <= 81 * 65536) ? 9 : 10,
  localparam int P = 2 * R + 1,
  localparam int Q = 4 * R + 1,
  localparam int PMAX = (1 << PIX_W) - 1,
  localparam int CW = $clog2(P * P * PMAX * PMAX + 1),
  localparam int XW = $clog2(IMG_W),
  localparam int YW = $clog2(IMG_H)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [XW-1:0]          in_x,
  input  logic [YW-1:0]          in_y,
  output logic                   fetch_en,
  output logic [XW-1:0]          fetch_x,
  output logic [YW-1:0]          fetch_y,
  input  logic [P*P*PIX_W-1:0]   cur_win,
  input  logic [Q*Q*PIX_W-1:0]   nxt_win,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [XW-1:0]          out_x,
  output logic [YW-1:0]          out_y,
  output logic [CW-1:0]          out_cost,
  output logic                   out_nomatch
);

  localparam int NOFF = P * P;
  localparam int LV   = $clog2(NOFF);
  localparam int NP   = 1 << LV;
  localparam int DW   = $clog2(2 * R + 1);
  localparam int SIW  = $clog2(P);
  localparam int KW   = CW + DW + 2 * SIW;
  localparam int CTR  = R * P + R;

  logic          adv;
  logic          s1_v, s1_oob, s2_v, s2_oob;
  logic [XW-1:0] s1_x, s2_x;
  logic [YW-1:0] s1_y, s2_y;
  logic          in_oob;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign in_oob   = (int'(in_x) < 2 * R) || (int'(in_x) > IMG_W - 1 - 2 * R) ||
                    (int'(in_y) < 2 * R) || (int'(in_y) > IMG_H - 1 - 2 * R);

  assign fetch_en = s1_v && !s1_oob && adv;
  assign fetch_x  = s1_x;
  assign fetch_y  = s1_y;

  logic [CW-1:0] cost [NOFF];
  logic [KW-1:0] node [2*NP-1];

  for (genvar k = 0; k < NP; k++) begin : g_leaf
    if (k < NOFF) begin : g_real
      localparam int SI = k / P;
      localparam int BI = k % P;
      localparam int DS = (SI > R ? SI - R : R - SI) + (BI > R ? BI - R : R - BI);
      always_comb begin
        int acc;
        int d;
        acc = 0;
        for (int v = 0; v < P; v++) begin
          for (int u = 0; u < P; u++) begin
            d = int'(cur_win[(v * P + u) * PIX_W +: PIX_W]) -
                int'(nxt_win[((SI + v) * Q + BI + u) * PIX_W +: PIX_W]);
            acc = acc + d * d;
          end
        end
        cost[k] = CW'(acc);
      end
      assign node[NP-1+k] = {cost[k], DW'(DS), SIW'(SI), SIW'(BI)};
    end else begin : g_pad
      assign node[NP-1+k] = '1;
    end
  end

  for (genvar n = 0; n < NP - 1; n++) begin : g_tree
    assign node[n] = (node[2*n+2] < node[2*n+1]) ? node[2*n+2] : node[2*n+1];
  end

  logic [CW-1:0]  win_cost;
  logic [DW-1:0]  win_dist;
  logic [SIW-1:0] win_s, win_b;
  assign {win_cost, win_dist, win_s, win_b} = node[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      s1_v      <= in_valid;
      s2_v      <= s1_v;
      out_valid <= s2_v;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_x   <= in_x;
      s1_y   <= in_y;
      s1_oob <= in_oob;
      s2_x   <= s1_x;
      s2_y   <= s1_y;
      s2_oob <= s1_oob;
      if (s2_oob) begin
        out_x       <= s2_x;
        out_y       <= s2_y;
        out_cost    <= '0;
        out_nomatch <= 1'b1;
      end else begin
        out_x       <= XW'(int'(s2_x) + int'(win_b) - R);
        out_y       <= YW'(int'(s2_y) + int'(win_s) - R);
        out_cost    <= win_cost;
        out_nomatch <= 1'b0;
      end
    end
  end

  a_r8_reset_idle: assert property (@(posedge clk) rst |=> !out_valid && !fetch_en && in_ready)
    else $error("a_r8_reset_idle");

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y) &&
                                $stable(out_cost) && $stable(out_nomatch))
    else $error("a_r6_hold");

  a_r6_no_take: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready)
    else $error("a_r6_no_take");

  a_r5_nomatch_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_nomatch |-> out_cost == '0)
    else $error("a_r5_nomatch_zero");

  a_r7_fetch_lands: assert property (@(posedge clk) disable iff (rst)
    fetch_en |=> s2_v && !s2_oob)
    else $error("a_r7_fetch_lands");

  a_r2_not_above_centre: assert property (@(posedge clk) disable iff (rst)
    s2_v && !s2_oob |-> win_cost <= cost[CTR])
    else $error("a_r2_not_above_centre");

  a_r3_centre_wins_tie: assert property (@(posedge clk) disable iff (rst)
    s2_v && !s2_oob && win_cost == cost[CTR] |-> win_dist == '0)
    else $error("a_r3_centre_wins_tie");

endmodule

// File: tb/ssd_tracker_bench.sv
module ssd_tracker_bench;
  localparam int W = 384, H = 256, R = 2, P = 5, Q = 9;

  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic in_valid = 0, in_ready, out_ready = 0;
  logic [8:0] in_x = 0;
  logic [7:0] in_y = 0;
  logic fetch_en, out_valid, out_nomatch;
  logic [8:0] fetch_x, out_x;
  logic [7:0] fetch_y, out_y;
  logic [20:0] out_cost;
  logic [P*P*8-1:0] cur_win = '0, cwv;
  logic [Q*Q*8-1:0] nxt_win = '0, nwv;

  ssd_tracker u_ssd_tracker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .fetch_en(fetch_en), .fetch_x(fetch_x),
    .fetch_y(fetch_y), .cur_win(cur_win), .nxt_win(nxt_win),
    .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x),
    .out_y(out_y), .out_cost(out_cost), .out_nomatch(out_nomatch));

  int checks = 0, errors = 0, scene = 0;
  bit done = 0;
  int qx[$], qy[$], qc[$], qn[$], fx[$], fy[$];

  function automatic int tex(int x, int y);
    return (x * x * 7 + y * y * 3 + x * y * 5 + x * 11 + 13) & 255;
  endfunction

  function automatic int pix(int sc, int fr, int x, int y);
    case (sc)
      0: return 77;
      1: return fr == 0 ? tex(x, y) : tex(x - 2, y + 1);
      2: return fr == 0 ? (((x + 1) & 1) != 0 ? 200 : 10) : ((x & 1) != 0 ? 200 : 10);
      default: return fr == 0 ? tex(x, y) : ((tex(x + 1, y - 2) + (x + y) % 3) & 255);
    endcase
  endfunction

  function automatic bit oob(int x, int y);
    return x < 2 * R || x > W - 1 - 2 * R || y < 2 * R || y > H - 1 - 2 * R;
  endfunction

  task automatic ref_match(int sc, int x, int y, output int ex, output int ey,
                           output int ec, output int en);
    int best, bd, c, d;
    if (oob(x, y)) begin
      ex = x; ey = y; ec = 0; en = 1;
      return;
    end
    best = 32'h7fffffff; bd = 99; ex = x; ey = y; en = 0;
    for (int s = -R; s <= R; s++)
      for (int b = -R; b <= R; b++) begin
        c = 0;
        for (int v = -R; v <= R; v++)
          for (int u = -R; u <= R; u++) begin
            d = pix(sc, 0, x + u, y + v) - pix(sc, 1, x + b + u, y + s + v);
            c += d * d;
          end
        if (c < best || (c == best && (b < 0 ? -b : b) + (s < 0 ? -s : s) < bd)) begin
          best = c; bd = (b < 0 ? -b : b) + (s < 0 ? -s : s); ex = x + b; ey = y + s;
        end
      end
    ec = best;
  endtask

  always @(posedge clk) begin
    if (fetch_en) begin
      checks++;
      if (fx.size() == 0 || fetch_x != fx[0] || fetch_y != fy[0]) begin
        errors++;
        $display("FAIL R7 fetch at (%0d,%0d) expected (%0d,%0d)", fetch_x, fetch_y,
                 fx.size() ? fx[0] : -1, fy.size() ? fy[0] : -1);
      end
      if (fx.size()) begin void'(fx.pop_front()); void'(fy.pop_front()); end
      for (int v = 0; v < P; v++)
        for (int u = 0; u < P; u++)
          cwv[(v * P + u) * 8 +: 8] = 8'(pix(scene, 0, fetch_x + u - R, fetch_y + v - R));
      for (int j = 0; j < Q; j++)
        for (int i = 0; i < Q; i++)
          nwv[(j * Q + i) * 8 +: 8] = 8'(pix(scene, 1, fetch_x + i - 2 * R, fetch_y + j - 2 * R));
      cur_win <= cwv;
      nxt_win <= nwv;
    end
  end

  bit held = 0;
  logic [8:0] hx; logic [7:0] hy; logic [20:0] hc; logic hn;
  int cyc = 0, stalls = 0, acc_cyc = -1, out_cyc = -1;
  string tag;

  task automatic cycle(bit v, int x, int y, bit rdy, output bit took);
    int ex, ey, ec, en;
    @(negedge clk);
    cyc++;
    if (held) begin
      checks++;
      if (!out_valid || out_x != hx || out_y != hy || out_cost != hc || out_nomatch != hn) begin
        errors++;
        $display("FAIL R6 held output changed: %0d,%0d,%0d,%0d expected %0d,%0d,%0d,%0d",
                 out_x, out_y, out_cost, out_nomatch, hx, hy, hc, hn);
      end
    end
    in_valid = v; in_x = 9'(x); in_y = 8'(y); out_ready = rdy;
    #1;
    held = out_valid && !out_ready;
    if (held) begin
      hx = out_x; hy = out_y; hc = out_cost; hn = out_nomatch;
      checks++;
      if (in_ready) begin errors++; $display("FAIL R6 in_ready 1 expected 0"); end
    end
    if (out_valid && out_ready) begin
      if (out_cyc < 0) out_cyc = cyc;
      checks++;
      if (qx.size() == 0) begin
        errors++; $display("FAIL R6 unexpected match %0d,%0d expected none", out_x, out_y);
      end else begin
        if (qn[0] != 0) tag = "R5";
        else if (scene == 0) tag = "R3";
        else if (scene == 1) tag = "R1";
        else if (scene == 2) tag = "R4";
        else tag = "R2";
        if (out_x != qx[0] || out_y != qy[0] || out_cost != qc[0] || out_nomatch != qn[0]) begin
          errors++;
          $display("FAIL %s match %0d,%0d cost %0d nm %0d expected %0d,%0d cost %0d nm %0d",
                   tag, out_x, out_y, out_cost, out_nomatch, qx[0], qy[0], qc[0], qn[0]);
        end
        void'(qx.pop_front()); void'(qy.pop_front()); void'(qc.pop_front()); void'(qn.pop_front());
      end
    end
    took = v && in_ready;
    if (v && !in_ready) stalls++;
    if (took) begin
      if (acc_cyc < 0) acc_cyc = cyc;
      ref_match(scene, x, y, ex, ey, ec, en);
      qx.push_back(ex); qy.push_back(ey); qc.push_back(ec); qn.push_back(en);
      if (!oob(x, y)) begin fx.push_back(x); fy.push_back(y); end
    end
  endtask

  initial begin
    int xs[6] = '{3, 4, 5, 192, 379, 380};
    int ys[6] = '{3, 4, 5, 128, 251, 252};
    bit took;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    #1;
    checks++;
    if (out_valid || fetch_en || !in_ready) begin
      errors++;
      $display("FAIL R8 reset out_valid=%0d fetch_en=%0d in_ready=%0d expected 0,0,1",
               out_valid, fetch_en, in_ready);
    end
    for (int sc = 0; sc < 4; sc++) begin
      scene = sc;
      stalls = 0; acc_cyc = -1; out_cyc = -1;
      for (int k = 0; k < 36; ) begin
        cycle(1, xs[k % 6], ys[k / 6], sc == 3 ? 1'b1 : ((cyc % 5) != 3), took);
        if (took) k++;
      end
      for (int g = 0; g < 50 && qx.size() != 0; g++) cycle(0, 0, 0, 1, took);
      checks++;
      if (qx.size() != 0 || fx.size() != 0) begin
        errors++;
        $display("FAIL R6 pending %0d matches %0d fetches expected 0", qx.size(), fx.size());
      end
      if (sc == 3) begin
        checks++;
        if (stalls != 0) begin errors++; $display("FAIL R9 stalls %0d expected 0", stalls); end
        checks++;
        if (out_cyc - acc_cyc != 3) begin
          errors++; $display("FAIL R9 latency %0d expected 3", out_cyc - acc_cyc);
        end
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule